// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block sits between a clock synthesizer's internal clocks and its output buffers. It gates one processor clock output and a bank of bus clock outputs (six by default). Two asynchronous active-low stop inputs, one for each clock group, and a set of per-output configuration bits decide whether each output runs. A gated output is always parked low. It never produces a shortened or stretched high pulse, whether it is stopping or restarting.

Each clock group has its own copy of the control path. The stop input and the configuration bits are first synchronized into the group's own clock. A small guard state machine then enforces a minimum run time after every restart. The resulting run decision is loaded into an enable flop on the falling edge of the source clock, so it can only change while that clock is low. The output is the source clock ANDed with that enable. Each bus output also has a free-running bit that makes it ignore the bus stop input. Stopping one group never reaches the enables of the other.

Top module: `clock_stop_gate`

## Requirements
- R1: While `rst_n` is low, every gated output stays low and produces no rising edge. The configuration synchronizers reset to "off".
- R2: An output's enable changes only on a falling edge of its source clock. A stopped output therefore reads low, and the first high pulse after a restart lasts a full source half period.
- R3: When `cpu_stop_n` goes low and is first sampled at processor clock rising edge P0, the output still pulses at P0 and P1 and is low from P2 on. A release sampled at P0 gives its first pulse at P2. Both latencies are two clocks, which is below four.
- R4: `pci_stop_n` follows the same timing for every bus output whose free-running bit is 0: sampled at bus clock edge P0, the last pulse is at P1, and a release gives its first pulse at P2.
- R5: Bit i of `pci_free` set to 1 makes `pci_clk_out[i]` ignore `pci_stop_n`. The output keeps running while bit i of `pci_on` is 1.
- R6: `cpu_on` = 0, or bit i of `pci_on` = 0, parks the matching output low regardless of the stop inputs. This applies even when bit i of `pci_free` is 1. These bits take effect with the same two-edge latency as the stop inputs.
- R7: After a processor clock restart, the output delivers at least `CPU_MIN_ON` (default 100) pulses before a new stop takes effect. If the stop is asserted again one clock after the release, exactly `CPU_MIN_ON` pulses appear.
- R8: The same minimum run rule holds for the bus outputs, with `PCI_MIN_ON` (default 10) pulses.
- R9: Stopping or disabling one clock group leaves every output of the other group toggling on every one of its source edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Internal processor clock source |
| pci_clk | input | 1 | Internal bus clock source |
| rst_n | input | 1 | Asynchronous active-low reset for both groups |
| cpu_stop_n | input | 1 | Asynchronous active-low stop request for the processor clock |
| pci_stop_n | input | 1 | Asynchronous active-low stop request for the bus clocks |
| cpu_on | input | 1 | Configuration enable of the processor clock output, 1 = run |
| pci_on | input | PCI_N | Configuration enable per bus output, bit i drives output i, 1 = run |
| pci_free | input | PCI_N | Free-running bit per bus output, 1 = ignore `pci_stop_n` |
| cpu_clk_out | output | 1 | Gated processor clock |
| pci_clk_out | output | PCI_N | Gated bus clocks |

## Verification
Every stop, release or configuration change is due at the second rising edge of the controlled clock after the edge that first samples it. The bench therefore changes inputs 1 ns after a rising edge. It reads output levels 1 ns into the following high phases, so a high level there marks a pulse and a low level marks a suppressed one. The minimum-run checks release a stopped group and re-request the stop one edge later. They then count pulses over a window longer than the guard and expect exactly 100 or 10. Table vectors wait 16 bus clocks before measuring, which is longer than the guard period plus latency, so each window sees only settled behaviour.

// File: rtl/csg_pkg.sv
`timescale 1ns/1ps
package csg_pkg;

  // Guard state of one clock group's stop path
  typedef enum logic [1:0] {
    HOLD_RUN   = 2'd0,  // running, a stop request is accepted
    HOLD_STOP  = 2'd1,  // stopped, waiting for a release
    HOLD_GUARD = 2'd2   // running after a restart, stop requests masked
  } hold_state_e;

  // Bits needed to hold values 0..max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  // Guard count loaded on restart so that exactly min_on pulses leave
  // the output before a waiting stop request is accepted
  function automatic int unsigned hold_load(input int unsigned min_on);
    return (min_on > 0) ? min_on - 1 : 0;
  endfunction

  // Rising source edges from the sampling edge to the first affected edge
  function automatic int unsigned edge_latency(input int unsigned stages);
    return stages;
  endfunction

endpackage

// File: rtl/csg_sync.sv
`timescale 1ns/1ps
module csg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= d;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[LAST];
endmodule

// File: rtl/csg_hold.sv
`timescale 1ns/1ps
module csg_hold
  import csg_pkg::*;
#(
  parameter int unsigned MIN_ON = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,       // synchronized stop request, 1 = stop
  output logic stop_eff   // stop decision after the guard
);
  localparam int unsigned W    = cnt_width(MIN_ON);
  localparam int unsigned LOAD = hold_load(MIN_ON);

  hold_state_e      state;
  logic [W-1:0]     cnt;

  // A request is honoured at once unless the guard is counting
  assign stop_eff = req && (state != HOLD_GUARD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HOLD_RUN;
      cnt   <= '0;
    end else begin
      case (state)
        HOLD_RUN: begin
          if (stop_eff) state <= HOLD_STOP;
        end
        HOLD_STOP: begin
          if (!stop_eff) begin
            if (LOAD == 0) begin
              state <= HOLD_RUN;
            end else begin
              state <= HOLD_GUARD;
              cnt   <= W'(LOAD);
            end
          end
        end
        HOLD_GUARD: begin
          if (cnt <= W'(1)) begin
            state <= HOLD_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt - W'(1);
          end
        end
        default: begin
          state <= HOLD_RUN;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/csg_gate.sv
`timescale 1ns/1ps
module csg_gate #(
  parameter int unsigned N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] run,
  output logic [N-1:0] en_q,
  output logic [N-1:0] clk_out
);
  // Enables move only on the falling edge, while the source is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= run;
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign clk_out[g] = clk & en_q[g];
  end
endmodule

// File: rtl/clock_stop_gate.sv
`timescale 1ns/1ps
module clock_stop_gate #(
  parameter int unsigned PCI_N       = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CPU_MIN_ON  = 100,
  parameter int unsigned PCI_MIN_ON  = 10
) (
  input  logic             cpu_clk,
  input  logic             pci_clk,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             cpu_on,
  input  logic [PCI_N-1:0] pci_on,
  input  logic [PCI_N-1:0] pci_free,
  output logic             cpu_clk_out,
  output logic [PCI_N-1:0] pci_clk_out
);
  localparam int unsigned CPU_SYNC_W = 2;
  localparam int unsigned PCI_SYNC_W = 1 + 2 * PCI_N;

  // ---------------- processor clock group ----------------
  logic [CPU_SYNC_W-1:0] cpu_raw, cpu_s;
  logic                  cpu_req_s, cpu_on_s;
  logic                  cpu_stop_eff;
  logic                  cpu_run;
  logic                  cpu_en_q;

  assign cpu_raw = {cpu_on, ~cpu_stop_n};

  csg_sync #(.WIDTH(CPU_SYNC_W), .STAGES(SYNC_STAGES)) u_cpu_sync (
    .clk(cpu_clk), .rst_n(rst_n), .d(cpu_raw), .q(cpu_s)
  );

  assign {cpu_on_s, cpu_req_s} = cpu_s;

  csg_hold #(.MIN_ON(CPU_MIN_ON)) u_cpu_hold (
    .clk(cpu_clk), .rst_n(rst_n), .req(cpu_req_s), .stop_eff(cpu_stop_eff)
  );

  assign cpu_run = cpu_on_s & ~cpu_stop_eff;

  csg_gate #(.N(1)) u_cpu_gate (
    .clk(cpu_clk), .rst_n(rst_n), .run(cpu_run),
    .en_q(cpu_en_q), .clk_out(cpu_clk_out)
  );

  // ---------------- bus clock group ----------------
  logic [PCI_SYNC_W-1:0] pci_raw, pci_s;
  logic                  pci_req_s;
  logic [PCI_N-1:0]      pci_on_s, pci_free_s;
  logic                  pci_stop_eff;
  logic [PCI_N-1:0]      pci_run;
  logic [PCI_N-1:0]      pci_en_q;

  assign pci_raw = {pci_free, pci_on, ~pci_stop_n};

  csg_sync #(.WIDTH(PCI_SYNC_W), .STAGES(SYNC_STAGES)) u_pci_sync (
    .clk(pci_clk), .rst_n(rst_n), .d(pci_raw), .q(pci_s)
  );

  assign {pci_free_s, pci_on_s, pci_req_s} = pci_s;

  csg_hold #(.MIN_ON(PCI_MIN_ON)) u_pci_hold (
    .clk(pci_clk), .rst_n(rst_n), .req(pci_req_s), .stop_eff(pci_stop_eff)
  );

  // Free-running lanes bypass the stop decision, never the enable bit
  assign pci_run = pci_on_s & (pci_free_s | {PCI_N{~pci_stop_eff}});

  csg_gate #(.N(PCI_N)) u_pci_gate (
    .clk(pci_clk), .rst_n(rst_n), .run(pci_run),
    .en_q(pci_en_q), .clk_out(pci_clk_out)
  );
endmodule

// File: rtl/csg_chk.sv
`timescale 1ns/1ps
module csg_chk
  import csg_pkg::*;
#(
  parameter int unsigned PCI_N      = 6,
  parameter int unsigned CPU_MIN_ON = 100,
  parameter int unsigned PCI_MIN_ON = 10
) (
  input logic             cpu_clk,
  input logic             pci_clk,
  input logic             rst_n,
  input logic             cpu_stop_eff,
  input logic             cpu_run,
  input logic             cpu_en_q,
  input logic             pci_stop_eff,
  input logic [PCI_N-1:0] pci_run,
  input logic [PCI_N-1:0] pci_en_q,
  input logic [PCI_N-1:0] pci_on_s,
  input logic [PCI_N-1:0] pci_free_s
);
  localparam int unsigned CW = cnt_width(CPU_MIN_ON);
  localparam int unsigned PW = cnt_width(PCI_MIN_ON);

  // Run-length counters since the last stop, saturating at the minimum
  logic [CW-1:0] cpu_since;
  logic [PW-1:0] pci_since;

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n)                       cpu_since <= CW'(CPU_MIN_ON);
    else if (cpu_stop_eff)            cpu_since <= '0;
    else if (cpu_since < CW'(CPU_MIN_ON)) cpu_since <= cpu_since + CW'(1);
  end

  always_ff @(posedge pci_clk or negedge rst_n) begin
    if (!rst_n)                       pci_since <= PW'(PCI_MIN_ON);
    else if (pci_stop_eff)            pci_since <= '0;
    else if (pci_since < PW'(PCI_MIN_ON)) pci_since <= pci_since + PW'(1);
  end

  AST_CPU_ENABLE_LOW_PHASE: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    cpu_en_q == cpu_run) else $error("cpu enable left the low phase"); // R2

  AST_CPU_STOP_PARKS: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    cpu_stop_eff |-> !cpu_en_q) else $error("cpu stop not parked"); // R3

  AST_CPU_MIN_RUN: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $rose(cpu_stop_eff) |-> cpu_since >= CW'(CPU_MIN_ON)) else $error("cpu guard short"); // R7

  AST_PCI_MIN_RUN: assert property (@(posedge pci_clk) disable iff (!rst_n)
    $rose(pci_stop_eff) |-> pci_since >= PW'(PCI_MIN_ON)) else $error("pci guard short"); // R8

  for (genvar g = 0; g < PCI_N; g++) begin : g_lane
    AST_PCI_ENABLE_LOW_PHASE: assert property (@(posedge pci_clk) disable iff (!rst_n)
      pci_en_q[g] == pci_run[g]) else $error("pci enable left the low phase"); // R2

    AST_PCI_STOP_PARKS: assert property (@(posedge pci_clk) disable iff (!rst_n)
      pci_stop_eff && !pci_free_s[g] |-> !pci_en_q[g]) else $error("pci stop not parked"); // R4

    AST_PCI_FREE_RUNS: assert property (@(posedge pci_clk) disable iff (!rst_n)
      pci_free_s[g] && pci_on_s[g] |-> pci_en_q[g]) else $error("free lane stopped"); // R5

    AST_PCI_OFF_PARKS: assert property (@(posedge pci_clk) disable iff (!rst_n)
      !pci_on_s[g] |-> !pci_en_q[g]) else $error("disabled lane running"); // R6
  end
endmodule

bind clock_stop_gate csg_chk #(
  .PCI_N(PCI_N), .CPU_MIN_ON(CPU_MIN_ON), .PCI_MIN_ON(PCI_MIN_ON)
) u_chk (
  .cpu_clk(cpu_clk), .pci_clk(pci_clk), .rst_n(rst_n),
  .cpu_stop_eff(cpu_stop_eff), .cpu_run(cpu_run), .cpu_en_q(cpu_en_q),
  .pci_stop_eff(pci_stop_eff), .pci_run(pci_run), .pci_en_q(pci_en_q),
  .pci_on_s(pci_on_s), .pci_free_s(pci_free_s)
);

// File: tb/clock_stop_gate_test.sv
`timescale 1ns/1ps
module clock_stop_gate_test;
  localparam int NP = 6;

  logic          cpu_clk = 1'b0;
  logic          pci_clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          cpu_stop_n = 1'b1;
  logic          pci_stop_n = 1'b1;
  logic          cpu_on = 1'b1;
  logic [NP-1:0] pci_on = '1;
  logic [NP-1:0] pci_free = '0;
  logic          cpu_clk_out;
  logic [NP-1:0] pci_clk_out;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  int  cpu_cnt = 0;
  real t_rise  = 0.0;
  real last_w  = 0.0;
  int  pcnt [NP];

  always #2 cpu_clk = ~cpu_clk;   // 250 MHz
  always #4 pci_clk = ~pci_clk;

  clock_stop_gate uut (
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .cpu_on(cpu_on), .pci_on(pci_on), .pci_free(pci_free),
    .cpu_clk_out(cpu_clk_out), .pci_clk_out(pci_clk_out)
  );

  always @(posedge cpu_clk_out) begin
    cpu_cnt = cpu_cnt + 1;
    t_rise  = $realtime;
  end
  always @(negedge cpu_clk_out) last_w = $realtime - t_rise;

  // {pci_on, pci_free, pci_stop_n, expected running lanes}
  localparam logic [18:0] VECS [8] = '{
    {6'h3F, 6'h00, 1'b1, 6'h3F},
    {6'h3F, 6'h00, 1'b0, 6'h00},
    {6'h3F, 6'h05, 1'b0, 6'h05},
    {6'h2A, 6'h05, 1'b0, 6'h00},
    {6'h2A, 6'h05, 1'b1, 6'h2A},
    {6'h1F, 6'h30, 1'b0, 6'h10},
    {6'h00, 6'h3F, 1'b1, 6'h00},
    {6'h3F, 6'h3F, 1'b0, 6'h3F}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cpu_edges(input int n);
    for (int e = 0; e < n; e++) @(posedge cpu_clk);
    #1;
  endtask

  // Count bus pulses by reading lane levels 1 ns into each high phase
  task automatic pci_edges(input int n);
    for (int e = 0; e < n; e++) begin
      @(posedge pci_clk);
      #1;
      for (int i = 0; i < NP; i++) if (pci_clk_out[i]) pcnt[i]++;
    end
  endtask

  task automatic pci_clear();
    for (int i = 0; i < NP; i++) pcnt[i] = 0;
  endtask

  initial begin
    int c0;
    pci_clear();
    #1 rst_n = 1'b0;
    cpu_edges(10);
    chk(cpu_cnt == 0, "R1 cpu pulses in reset", cpu_cnt, 0);
    chk(pci_clk_out == '0 && cpu_clk_out == 1'b0, "R1 outputs low in reset", int'(pci_clk_out), 0);

    @(negedge cpu_clk); #1 rst_n = 1'b1;
    pci_edges(20);

    // R3 baseline and off latency
    @(posedge cpu_clk); #1;
    c0 = cpu_cnt;
    cpu_edges(8);
    chk(cpu_cnt - c0 == 8, "R3 cpu running", cpu_cnt - c0, 8);
    @(posedge cpu_clk); #1 cpu_stop_n = 1'b0;
    c0 = cpu_cnt;
    cpu_edges(2);
    chk(cpu_cnt - c0 == 2, "R3 cpu last pulse at P1", cpu_cnt - c0, 2);
    cpu_edges(1);
    chk(cpu_clk_out == 1'b0, "R2 cpu parked low", int'(cpu_clk_out), 0);
    chk(cpu_cnt - c0 == 2, "R3 cpu stopped at P2", cpu_cnt - c0, 2);

    // R9 bus group unaffected by the cpu stop
    pci_clear();
    pci_edges(4);
    for (int i = 0; i < NP; i++) chk(pcnt[i] == 4, "R9 pci runs while cpu stopped", pcnt[i], 4);
    chk(cpu_cnt - c0 == 2, "R3 cpu stays stopped", cpu_cnt - c0, 2);

    // R3 restart latency, R2 full first pulse
    @(posedge cpu_clk); #1 cpu_stop_n = 1'b1;
    c0 = cpu_cnt;
    cpu_edges(2);
    chk(cpu_cnt - c0 == 0, "R3 cpu no pulse before P2", cpu_cnt - c0, 0);
    cpu_edges(1);
    chk(cpu_cnt - c0 == 1, "R3 cpu first pulse at P2", cpu_cnt - c0, 1);
    #2;
    chk(last_w > 1.99 && last_w < 2.01, "R2 cpu first pulse full width",
        int'(last_w * 1000.0), 2000);

    // R7 minimum run after restart
    cpu_edges(120);
    @(posedge cpu_clk); #1 cpu_stop_n = 1'b0;
    cpu_edges(10);
    c0 = cpu_cnt;
    @(posedge cpu_clk); #1 cpu_stop_n = 1'b1;
    @(posedge cpu_clk); #1 cpu_stop_n = 1'b0;
    cpu_edges(150);
    chk(cpu_cnt - c0 == 100, "R7 cpu minimum run pulses", cpu_cnt - c0, 100);

    // R6 cpu configuration disable
    cpu_stop_n = 1'b1;
    cpu_edges(150);
    @(posedge cpu_clk); #1 cpu_on = 1'b0;
    c0 = cpu_cnt;
    cpu_edges(2);
    chk(cpu_cnt - c0 == 2, "R6 cpu disable last pulse at P1", cpu_cnt - c0, 2);
    cpu_edges(10);
    chk(cpu_cnt - c0 == 2, "R6 cpu disabled parked", cpu_cnt - c0, 2);
    cpu_on = 1'b1;
    cpu_edges(10);

    // R4 R5 R6 R9 table
    for (int v = 0; v < 8; v++) begin
      @(posedge pci_clk); #1;
      pci_on     = VECS[v][18:13];
      pci_free   = VECS[v][12:7];
      pci_stop_n = VECS[v][6];
      pci_edges(16);
      pci_clear();
      c0 = cpu_cnt;
      pci_edges(4);
      for (int i = 0; i < NP; i++) begin
        int exp_n;
        exp_n = VECS[v][i] ? 4 : 0;
        chk(pcnt[i] == exp_n, "R4/R5/R6 table lane pulses (R5 R6)", pcnt[i], exp_n);
      end
      chk(cpu_cnt - c0 == 8, "R9 cpu runs during bus vectors", cpu_cnt - c0, 8);
    end

    // R4 latency
    pci_on = '1; pci_free = '0; pci_stop_n = 1'b1;
    pci_edges(16);
    @(posedge pci_clk); #1 pci_stop_n = 1'b0;
    pci_edges(2);
    chk(pci_clk_out == '1, "R4 pci pulse at P1", int'(pci_clk_out), 63);
    pci_edges(1);
    chk(pci_clk_out == '0, "R4 pci parked at P2", int'(pci_clk_out), 0);
    pci_edges(16);
    @(posedge pci_clk); #1 pci_stop_n = 1'b1;
    pci_edges(2);
    chk(pci_clk_out == '0, "R4 pci no pulse before P2", int'(pci_clk_out), 0);
    pci_edges(1);
    chk(pci_clk_out == '1, "R4 pci first pulse at P2", int'(pci_clk_out), 63);

    // R8 minimum run after restart
    pci_edges(16);
    @(posedge pci_clk); #1 pci_stop_n = 1'b0;
    pci_edges(16);
    pci_clear();
    @(posedge pci_clk); #1 pci_stop_n = 1'b1;
    @(posedge pci_clk); #1 pci_stop_n = 1'b0;
    for (int i = 0; i < NP; i++) if (pci_clk_out[i]) pcnt[i]++;
    pci_edges(30);
    chk(pcnt[0] == 10, "R8 pci minimum run pulses", pcnt[0], 10);
    chk(pcnt[5] == 10, "R8 pci minimum run pulses lane 5", pcnt[5], 10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule